// File: doc/BRIEF.md
# SPI Peripheral Status and Data Register Block

This block is the processor-facing register pair of a byte-wide SPI peripheral in a small 8-bit microcontroller. It has a status register and a data register on the special-function-register bus. The status register reports two flags. One flag is raised when a byte transfer completes. The other is raised when software writes the data register while a transfer is still under way. A write to the data register while the engine is idle loads the byte that goes out to the shift engine and asks the engine to start with a one-clock pulse. The shift engine is outside this block. It is seen here only through a busy level and a one-clock completion pulse.

Software clears the flags with a two-step sequence. First it reads the status register while at least one flag is set, which arms an internal bit. Then it reads or writes the data register. Any data-register access without that earlier status read leaves the flags alone. The interrupt request follows the completion flag, gated by two enable inputs. Reset leaves the data register untouched.

Top module: `spi_sfr_regs`

## Requirements
- R1: Reset clears both flags, the arming bit, the start pulse and the interrupt request, and it leaves the data register (`tx_byte`) unchanged.
- R2: A one-clock `xfer_done` pulse sets `flag_done` on the next clock edge, and the flag then holds until the clearing sequence of R7 completes.
- R3: `irq` is 1 exactly when `flag_done` is 1, `spi_irq_en` is 1 and `ser_irq_en` is 1.
- R4: A write to the data register (address 0x86) sets `flag_coll` while a transfer is in progress. A transfer is in progress when `xfer_busy` is 1 or `xfer_start` is 1.
- R5: A data-register write during a transfer leaves `tx_byte` unchanged and produces no start pulse.
- R6: A read at status address 0xAA returns `flag_done` in bit 7, `flag_coll` in bit 6 and 0 in bits 5..0. A read at address 0x86 returns the data register. Any other address returns 0x00.
- R7: Two steps clear both flags on the next clock edge and disarm the sequence. The first is a status read taken while either flag is 1. The second is any later read or write of the data register.
- R8: A data-register access without prior arming leaves the flags unchanged. A status read taken while both flags are 0 does not arm the sequence.
- R9: A data-register write while no transfer is in progress loads `tx_byte` with the written byte on the next clock edge, and it raises `xfer_start` for exactly that one cycle.
- R10: Two events can arrive in the same cycle as the clearing access: a completion pulse or a collision write. If so, the matching flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_rd | input | 1 | Register bus read strobe |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| spi_irq_en | input | 1 | Peripheral interrupt enable |
| ser_irq_en | input | 1 | Serial-group interrupt enable |
| xfer_busy | input | 1 | Shift engine is transferring |
| xfer_done | input | 1 | One-clock transfer completion pulse |
| tx_byte | output | 8 | Data register contents for the shift engine |
| xfer_start | output | 1 | One-clock start request to the shift engine |
| flag_done | output | 1 | Transfer-complete flag |
| flag_coll | output | 1 | Write-collision flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the clearing access landing in the same cycle as a new completion pulse or a new collision, and a data write landing in the single cycle after a load, where `xfer_start` is high but `xfer_busy` has not yet risen. Directed sequences build these cases on purpose: the bench arms the sequence, then issues the data access together with `xfer_done` or with `xfer_busy` held high. It also writes twice back to back. A long run of seeded random traffic follows, mixing status reads, data accesses, foreign addresses, busy levels and completion pulses. This traffic produces many more such overlaps, and a bench-side model of the flag, arming and data rules checks every cycle.

// File: rtl/spi_sfr_pkg.sv
package spi_sfr_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2
   } sfr_sel_e;
endpackage

// File: rtl/spi_sfr_decode.sv
module spi_sfr_decode
   import spi_sfr_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hAA,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h86
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output sfr_sel_e          sel,
   output logic              stat_rd,
   output logic              data_wr,
   output logic              data_acc
);
   always_comb begin
      if (addr == STAT_ADDR)      sel = SEL_STAT;
      else if (addr == DATA_ADDR) sel = SEL_DATA;
      else                        sel = SEL_NONE;
   end

   assign stat_rd  = rd & (sel == SEL_STAT);
   assign data_wr  = wr & (sel == SEL_DATA);
   assign data_acc = (rd | wr) & (sel == SEL_DATA);
endmodule

// File: rtl/spi_sfr_flags.sv
module spi_sfr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_done,
   input  logic coll_evt,
   input  logic stat_rd,
   input  logic data_acc,
   output logic done_q,
   output logic coll_q,
   output logic armed_q
);
   logic clr;

   // the second step of the sequence only counts once the first one armed it
   assign clr = data_acc & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         coll_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         // new events override a clear in the same cycle
         done_q <= xfer_done | (done_q & ~clr);
         coll_q <= coll_evt  | (coll_q & ~clr);
         if (clr)
            armed_q <= 1'b0;
         else if (stat_rd && (done_q || coll_q))
            armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_sfr_data.sv
module spi_sfr_data #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              xfer_busy,
   output logic [DATA_W-1:0] data_q,
   output logic              start_q,
   output logic              coll_evt
);
   logic in_prog;
   logic load;

   // the start cycle counts as in progress: the engine has not yet raised busy
   assign in_prog  = xfer_busy | start_q;
   assign load     = data_wr & ~in_prog;
   assign coll_evt = data_wr & in_prog;

   // holding register has no reset on purpose
   always_ff @(posedge clk) begin
      if (load) data_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= load;
   end
endmodule

// File: rtl/spi_sfr_regs.sv
module spi_sfr_regs
   import spi_sfr_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hAA,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h86,
   parameter int                DONE_BIT  = 7,
   parameter int                COLL_BIT  = 6,
   parameter bit                IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_rd,
   input  logic              sfr_wr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   input  logic              spi_irq_en,
   input  logic              ser_irq_en,
   input  logic              xfer_busy,
   input  logic              xfer_done,
   output logic [DATA_W-1:0] tx_byte,
   output logic              xfer_start,
   output logic              flag_done,
   output logic              flag_coll,
   output logic              irq
);
   if (DATA_W < 2) begin : g_bad_width
      $error("spi_sfr_regs: DATA_W must be at least 2");
   end
   if (DONE_BIT >= DATA_W || COLL_BIT >= DATA_W || DONE_BIT < 0 || COLL_BIT < 0) begin : g_bad_bit
      $error("spi_sfr_regs: flag bit position outside the data width");
   end
   if (DONE_BIT == COLL_BIT) begin : g_bad_overlap
      $error("spi_sfr_regs: flag bit positions must differ");
   end
   if (STAT_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("spi_sfr_regs: register addresses must differ");
   end

   sfr_sel_e sel;
   logic     stat_rd, data_wr, data_acc;
   logic     coll_evt;
   logic     armed_w;
   logic     irq_cond;

   spi_sfr_decode #(
      .ADDR_W   (ADDR_W),
      .STAT_ADDR(STAT_ADDR),
      .DATA_ADDR(DATA_ADDR)
   ) u_decode (
      .addr    (sfr_addr),
      .rd      (sfr_rd),
      .wr      (sfr_wr),
      .sel     (sel),
      .stat_rd (stat_rd),
      .data_wr (data_wr),
      .data_acc(data_acc)
   );

   spi_sfr_data #(.DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr),
      .wdata    (sfr_wdata),
      .xfer_busy(xfer_busy),
      .data_q   (tx_byte),
      .start_q  (xfer_start),
      .coll_evt (coll_evt)
   );

   spi_sfr_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer_done(xfer_done),
      .coll_evt (coll_evt),
      .stat_rd  (stat_rd),
      .data_acc (data_acc),
      .done_q   (flag_done),
      .coll_q   (flag_coll),
      .armed_q  (armed_w)
   );

   assign irq_cond = flag_done & spi_irq_en & ser_irq_en;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_cond;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_cond;
   end

   always_comb begin
      sfr_rdata = '0;
      case (sel)
         SEL_STAT: begin
            sfr_rdata[DONE_BIT] = flag_done;
            sfr_rdata[COLL_BIT] = flag_coll;
         end
         SEL_DATA: sfr_rdata = tx_byte;
         default:  sfr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_sfr_regs_chk.sv
module spi_sfr_regs_chk #(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h86,
   parameter bit                IRQ_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sfr_addr,
   input logic              sfr_rd,
   input logic              sfr_wr,
   input logic              xfer_busy,
   input logic              xfer_done,
   input logic              xfer_start,
   input logic              flag_done,
   input logic              flag_coll,
   input logic              armed,
   input logic [DATA_W-1:0] tx_byte,
   input logic              spi_irq_en,
   input logic              ser_irq_en,
   input logic              irq
);
   logic wr_d, acc_d, busy_now;
   assign wr_d     = sfr_wr && (sfr_addr == DATA_ADDR);
   assign acc_d    = (sfr_wr || sfr_rd) && (sfr_addr == DATA_ADDR);
   assign busy_now = xfer_busy || xfer_start;

   AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> flag_done); // R2
   AST_COLL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && busy_now) |=> flag_coll); // R4
   AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && busy_now) |=> ($stable(tx_byte) && !xfer_start)); // R5
   AST_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d && armed && !xfer_done) |=> (!flag_done && !armed)); // R7
   AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d && !armed && flag_done) |=> flag_done); // R8
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start); // R9
   AST_START_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && !busy_now) |=> xfer_start); // R9
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d && armed && xfer_done) |=> flag_done); // R10

   if (IRQ_REG) begin : g_chk_irq_reg
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(flag_done && spi_irq_en && ser_irq_en)); // R3
   end else begin : g_chk_irq_comb
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (flag_done && spi_irq_en && ser_irq_en)); // R3
   end
endmodule

bind spi_sfr_regs spi_sfr_regs_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .DATA_ADDR(DATA_ADDR),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sfr_addr  (sfr_addr),
   .sfr_rd    (sfr_rd),
   .sfr_wr    (sfr_wr),
   .xfer_busy (xfer_busy),
   .xfer_done (xfer_done),
   .xfer_start(xfer_start),
   .flag_done (flag_done),
   .flag_coll (flag_coll),
   .armed     (armed_w),
   .tx_byte   (tx_byte),
   .spi_irq_en(spi_irq_en),
   .ser_irq_en(ser_irq_en),
   .irq       (irq)
);

// File: tb/spi_sfr_regs_test.sv
`timescale 1ns/1ps
module spi_sfr_regs_test;
   localparam logic [7:0] A_STAT = 8'hAA;
   localparam logic [7:0] A_DATA = 8'h86;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = '0;
   logic       sfr_rd = 1'b0, sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = '0;
   logic [7:0] sfr_rdata;
   logic       spi_irq_en = 1'b0, ser_irq_en = 1'b0;
   logic       xfer_busy = 1'b0, xfer_done = 1'b0;
   logic [7:0] tx_byte;
   logic       xfer_start, flag_done, flag_coll, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model state
   logic       e_done = 1'b0, e_coll = 1'b0, e_armed = 1'b0, e_start = 1'b0;
   logic [7:0] e_data = '0;
   bit         e_dv = 1'b0;

   always #2.5 clk = ~clk;

   spi_sfr_regs uut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .spi_irq_en(spi_irq_en),
      .ser_irq_en(ser_irq_en), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
      .tx_byte(tx_byte), .xfer_start(xfer_start), .flag_done(flag_done),
      .flag_coll(flag_coll), .irq(irq)
   );

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == A_STAT)      return {e_done, e_coll, 6'b000000};
      else if (a == A_DATA) return e_data;
      else                  return 8'h00;
   endfunction

   function automatic logic exp_irq(input logic ea, input logic es);
      return e_done & ea & es;
   endfunction

   // one clock of bus activity, with the model advanced and all outputs checked
   task automatic step(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d,
                       input logic b, input logic dn, input logic ea, input logic es);
      logic wr_d, acc, rd_s, inprog, clr;
      sfr_addr = a; sfr_rd = r; sfr_wr = w; sfr_wdata = d;
      xfer_busy = b; xfer_done = dn; spi_irq_en = ea; ser_irq_en = es;
      #1;
      if (a != A_DATA || e_dv) check8("R6 read data", sfr_rdata, exp_read(a));
      check8("R3 irq", {7'd0, irq}, {7'd0, exp_irq(ea, es)});
      wr_d   = w && (a == A_DATA);
      acc    = (w || r) && (a == A_DATA);
      rd_s   = r && (a == A_STAT);
      inprog = b | e_start;
      clr    = acc & e_armed;
      @(posedge clk);
      #1;
      if (clr) e_armed = 1'b0;
      else if (rd_s && (e_done || e_coll)) e_armed = 1'b1;
      e_done  = dn | (e_done & ~clr);
      e_coll  = (wr_d & inprog) | (e_coll & ~clr);
      e_start = wr_d & ~inprog;
      if (wr_d && !inprog) begin e_data = d; e_dv = 1'b1; end
      check8("R2 flag_done", {7'd0, flag_done}, {7'd0, e_done});
      check8("R4 flag_coll", {7'd0, flag_coll}, {7'd0, e_coll});
      check8("R9 xfer_start", {7'd0, xfer_start}, {7'd0, e_start});
      if (e_dv) check8("R5 tx_byte", tx_byte, e_data);
   endtask

   task automatic idle();
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic do_reset();
      sfr_rd = 1'b0; sfr_wr = 1'b0; xfer_done = 1'b0; xfer_busy = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      e_done = 1'b0; e_coll = 1'b0; e_armed = 1'b0; e_start = 1'b0;
      #1;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      spi_irq_en = 1'b1; ser_irq_en = 1'b1;
      do_reset();
      // R1 reset state
      check8("R1 flag_done after reset", {7'd0, flag_done}, 8'h00);
      check8("R1 flag_coll after reset", {7'd0, flag_coll}, 8'h00);
      check8("R1 irq after reset", {7'd0, irq}, 8'h00);
      check8("R1 xfer_start after reset", {7'd0, xfer_start}, 8'h00);

      // R9 idle write loads and starts
      step(A_DATA, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R9 start after idle write", {7'd0, xfer_start}, 8'h01);
      check8("R9 tx_byte loaded", tx_byte, 8'h3C);
      // R4/R5 write in the start cycle (busy not yet high)
      step(A_DATA, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R4 collision in start cycle", {7'd0, flag_coll}, 8'h01);
      check8("R5 tx_byte kept", tx_byte, 8'h3C);
      check8("R5 no second start", {7'd0, xfer_start}, 8'h00);
      // write while busy
      step(A_DATA, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b1);
      check8("R5 tx_byte kept while busy", tx_byte, 8'h3C);
      // completion
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
      check8("R2 done set", {7'd0, flag_done}, 8'h01);
      check8("R3 irq both enables", {7'd0, irq}, 8'h01);
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
      // R8 unarmed data read does nothing
      step(A_DATA, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R8 unarmed access keeps done", {7'd0, flag_done}, 8'h01);
      check8("R8 unarmed access keeps coll", {7'd0, flag_coll}, 8'h01);
      // R6 status read returns C0, arms
      sfr_addr = A_STAT; #1;
      check8("R6 status image", sfr_rdata, 8'hC0);
      step(A_STAT, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      idle();
      // R7 data access clears
      step(A_DATA, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R7 done cleared", {7'd0, flag_done}, 8'h00);
      check8("R7 coll cleared", {7'd0, flag_coll}, 8'h00);
      // R8 status read with flags clear does not arm
      step(A_STAT, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
      step(A_DATA, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R8 read while clear does not arm", {7'd0, flag_done}, 8'h01);
      // R10 arm, then clearing access together with a new completion
      step(A_STAT, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      step(A_DATA, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
      check8("R10 new completion wins", {7'd0, flag_done}, 8'h01);
      // R10 clearing write that collides
      step(A_STAT, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      step(A_DATA, 1'b0, 1'b1, 8'h77, 1'b1, 1'b0, 1'b1, 1'b1);
      check8("R10 collision wins over clear", {7'd0, flag_coll}, 8'h01);
      check8("R10 done cleared by that write", {7'd0, flag_done}, 8'h00);
      step(A_STAT, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      step(A_DATA, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      check8("R7 collision cleared", {7'd0, flag_coll}, 8'h00);
      // R6 foreign address
      step(8'h55, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      // R1 data register survives reset
      step(A_DATA, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
      idle();
      step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
      do_reset();
      check8("R1 tx_byte unchanged by reset", tx_byte, 8'h5A);
      check8("R1 done cleared by reset", {7'd0, flag_done}, 8'h00);

      // seeded random traffic
      for (int i = 0; i < 4000; i++) begin
         int unsigned op;
         logic [7:0] a;
         logic r, w;
         op = $urandom % 6;
         r = 1'b0; w = 1'b0; a = 8'h00;
         case (op)
            1: begin a = A_STAT; r = 1'b1; end
            2: begin a = A_DATA; r = 1'b1; end
            3: begin a = A_DATA; w = 1'b1; end
            4: begin a = 8'($urandom); r = 1'b1; end
            5: begin a = 8'($urandom); w = 1'b1; end
            default: ;
         endcase
         step(a, r, w, 8'($urandom), ($urandom % 3) == 0, ($urandom % 8) == 0,
              1'($urandom), 1'($urandom));
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule